// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a network controller's data mover. Frames arrive as a byte stream with a last-byte marker and a CRC-error flag. For each frame the engine reads the next receive descriptor from a ring in memory. When the host has armed that descriptor, the engine copies the frame bytes into the buffer the descriptor names. It then writes back the length and the error causes and hands the descriptor back to the host.

Each descriptor is 16 bytes long. Word 0 holds the status and control bits. Word 1 is not used by this block. Word 2 holds the buffer byte address, and word 3 holds the upper address bits, which this block ignores. The ring base is given as a word address aligned to 256 bytes. The engine raises a receive-OK or a receive-error interrupt request for each completed frame. When it finds a descriptor still owned by the host, it discards the frame and counts it as missed.

Memory is reached through a single word-addressed port. A read returns its data one cycle after the request, and a write completes in the cycle it is issued. Software uses a small write port for two things: to acknowledge interrupt bits and to clear the missed-frame counter.

Top module: `rxr_engine`

## Requirements
- R1: When a frame begins, the engine reads word 0 of descriptor `idx` at word address `ring_base + 4*idx`. Status bit 31 set means the engine owns the descriptor. Bits 12:0 give the buffer capacity in bytes. Bit 30 marks the last descriptor in the ring. The index is 0 after reset.
- R2: The frame bytes go to the buffer whose byte address is in descriptor word 2 (word address `ring_base + 4*idx + 2`). Bytes are packed little-endian, with byte n in lane n mod 4 of buffer word n/4. A final partial word is written with its unused upper lanes as zero. The port never reads and writes in the same cycle.
- R3: After the last byte, word 0 of the descriptor is rewritten. Bits 12:0 hold the stored byte count, which includes the 4-byte CRC. Bit 31 is cleared, bit 30 keeps its armed value, and all other bits outside the error bits are zero.
- R4: If the CRC-error flag is high with the last byte, the written-back status has bit 19 and the summary bit 21 set.
- R5: A frame shorter than 64 bytes, counting the CRC, sets bit 20 and bit 21 in the written-back status.
- R6: A frame longer than the capacity has only its first capacity bytes stored. No memory word past the capacity is written. The length field equals the capacity, and bits 22 and 21 are set.
- R7: After a descriptor whose bit 30 is set, the next frame uses index 0. Otherwise it uses the next index.
- R8: `irq_status` bit 0 is set by a frame completed without error, and bit 1 by a frame completed with any error. A host write to address 0 clears each bit whose data bit is 1. Bits written as 0 are unchanged.
- R9: If word 0 has bit 31 clear when a frame begins, the frame is consumed without any memory write, `missed_count` increments by one, and the index does not advance.
- R10: A host write to address 1 clears `missed_count` to zero.
- R11: `in_ready` is high only while the engine is storing or discarding a frame. It is never high while a descriptor read is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | ADDR_W-2 | Word address of descriptor 0 |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Last byte of frame |
| in_crc_err | input | 1 | CRC error, qualified by in_last |
| in_ready | output | 1 | Byte accepted when high with in_valid |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, one cycle after mem_re |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 1 | 0: interrupt status, 1: missed counter |
| host_wdata | input | 2 | Host write data |
| irq_status | output | 2 | Bit 0 receive OK, bit 1 receive error |
| missed_count | output | 32 | Frames dropped for lack of a descriptor |

## Verification
A wrong descriptor index or a stale buffer pointer shows up at the memory port at the first data write of the next frame, as a write to an unexpected word address. Because the bench compares every write in order against its own queue of expected writes, the error is reported in that same cycle. A wrong byte count or a wrong error latch only becomes visible at the status writeback one cycle after the last byte, and the interrupt bits change at that same moment. A miscounted drop shows in `missed_count` one cycle after the descriptor read returns, and it also causes the next data write to land in the wrong buffer.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int ST_OWN   = 31;
    localparam int ST_EOR   = 30;
    localparam int ST_LONG  = 22;
    localparam int ST_ANY   = 21;
    localparam int ST_SHORT = 20;
    localparam int ST_CRC   = 19;
    localparam int LEN_W    = 13;
    localparam int CNT_W    = 16;
    localparam int MIN_FRAME = 64;

    typedef enum logic [2:0] {
        S_IDLE, S_RD_STAT, S_RD_BUF, S_RECV, S_DROP, S_WBACK
    } rx_state_e;

    typedef struct packed {
        logic crc;
        logic short_f;
        logic long_f;
    } rx_err_t;

    function automatic logic [31:0] make_status(input logic eor, input rx_err_t e,
                                                input logic [LEN_W-1:0] len);
        logic [31:0] w;
        w = '0;
        w[LEN_W-1:0] = len;
        w[ST_EOR]    = eor;
        w[ST_CRC]    = e.crc;
        w[ST_SHORT]  = e.short_f;
        w[ST_LONG]   = e.long_f;
        w[ST_ANY]    = e.crc | e.short_f | e.long_f;
        return w;
    endfunction
endpackage

// File: rtl/rxr_frame_meter.sv
module rxr_frame_meter
    import rxr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             last,
    input  logic             crc_in,
    input  logic [LEN_W-1:0] cap,
    output logic [CNT_W-1:0] cnt,
    output logic             fits,
    output logic             at_cap_edge,
    output rx_err_t          errs,
    output logic [LEN_W-1:0] len
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             crc_q;
    logic [CNT_W-1:0] cap_x;

    assign cap_x       = CNT_W'(cap);
    assign fits        = cnt < cap_x;
    assign at_cap_edge = (cnt + CNT_W'(1)) == cap_x;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            crc_q <= 1'b0;
        end else if (take) begin
            if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
            if (last) crc_q <= crc_in;
        end
    end

    always_comb begin
        errs.crc     = crc_q;
        errs.short_f = cnt < CNT_W'(MIN_FRAME);
        errs.long_f  = cnt > cap_x;
        len          = errs.long_f ? cap : cnt[LEN_W-1:0];
    end
endmodule

// File: rtl/rxr_byte_packer.sv
module rxr_byte_packer (
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        push,
    input  logic        flush,
    input  logic [1:0]  lane,
    input  logic [7:0]  data,
    output logic [31:0] word
);
    logic [31:0] acc;

    assign word = acc | (32'(data) << {lane, 3'b000});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (push) begin
            if (flush) acc <= '0;
            else       acc <= word;
        end
    end
endmodule

// File: rtl/rxr_irq_regs.sv
module rxr_irq_regs (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_ok,
    input  logic        set_err,
    input  logic        miss_inc,
    input  logic        host_wr,
    input  logic        host_addr,
    input  logic [1:0]  host_wdata,
    output logic [1:0]  irq_status,
    output logic [31:0] missed_count
);
    logic [1:0] clr_mask;

    assign clr_mask = (host_wr && !host_addr) ? host_wdata : 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_status   <= '0;
            missed_count <= '0;
        end else begin
            irq_status <= (irq_status & ~clr_mask) | {set_err, set_ok};
            if (host_wr && host_addr)  missed_count <= '0;
            else if (miss_inc)         missed_count <= missed_count + 32'd1;
        end
    end
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
    import rxr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-3:0] ring_base,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              in_crc_err,
    output logic              in_ready,
    output logic              mem_re,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              host_wr,
    input  logic              host_addr,
    input  logic [1:0]        host_wdata,
    output logic [1:0]        irq_status,
    output logic [31:0]       missed_count
);
    localparam int WAW = ADDR_W - 2;

    rx_state_e        state, state_n;
    logic [IDX_W-1:0] idx;
    logic             eor_q;
    logic [LEN_W-1:0] cap_q;
    logic [WAW-1:0]   buf_word;
    logic [WAW-1:0]   stat_word;

    logic             take, store, flush;
    logic [CNT_W-1:0] cnt;
    logic             fits, at_cap_edge;
    rx_err_t          errs;
    logic [LEN_W-1:0] wb_len;
    logic [31:0]      packed_word;
    logic             set_ok, set_err, miss_inc;

    assign stat_word = ring_base + WAW'({idx, 2'b00});
    assign in_ready  = (state == S_RECV) || (state == S_DROP);
    assign take      = in_ready && in_valid;
    assign store     = take && (state == S_RECV) && fits;
    assign flush     = store && ((cnt[1:0] == 2'd3) || in_last || at_cap_edge);

    rxr_frame_meter u_meter (
        .clk(clk), .rst(rst), .clr(state == S_RD_BUF),
        .take(take && state == S_RECV), .last(in_last), .crc_in(in_crc_err),
        .cap(cap_q), .cnt(cnt), .fits(fits), .at_cap_edge(at_cap_edge),
        .errs(errs), .len(wb_len)
    );

    rxr_byte_packer u_pack (
        .clk(clk), .rst(rst), .clr(state == S_RD_BUF),
        .push(store), .flush(flush), .lane(cnt[1:0]), .data(in_data),
        .word(packed_word)
    );

    rxr_irq_regs u_irq (
        .clk(clk), .rst(rst), .set_ok(set_ok), .set_err(set_err),
        .miss_inc(miss_inc), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .irq_status(irq_status),
        .missed_count(missed_count)
    );

    always_comb begin
        state_n   = state;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = stat_word;
        mem_wdata = '0;
        set_ok    = 1'b0;
        set_err   = 1'b0;
        miss_inc  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (in_valid) begin
                    mem_re  = 1'b1;
                    state_n = S_RD_STAT;
                end
            end
            S_RD_STAT: begin
                if (mem_rdata[ST_OWN]) begin
                    mem_re   = 1'b1;
                    mem_addr = stat_word + WAW'(2);
                    state_n  = S_RD_BUF;
                end else begin
                    miss_inc = 1'b1;
                    state_n  = S_DROP;
                end
            end
            S_RD_BUF: state_n = S_RECV;
            S_RECV: begin
                if (flush) begin
                    mem_we    = 1'b1;
                    mem_addr  = buf_word + WAW'(cnt[CNT_W-1:2]);
                    mem_wdata = packed_word;
                end
                if (take && in_last) state_n = S_WBACK;
            end
            S_DROP: begin
                if (take && in_last) state_n = S_IDLE;
            end
            S_WBACK: begin
                mem_we    = 1'b1;
                mem_wdata = make_status(eor_q, errs, wb_len);
                set_err   = errs.crc | errs.short_f | errs.long_f;
                set_ok    = !set_err;
                state_n   = S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            idx      <= '0;
            eor_q    <= 1'b0;
            cap_q    <= '0;
            buf_word <= '0;
        end else begin
            state <= state_n;
            if (state == S_RD_STAT && mem_rdata[ST_OWN]) begin
                eor_q <= mem_rdata[ST_EOR];
                cap_q <= mem_rdata[LEN_W-1:0];
            end
            if (state == S_RD_BUF) buf_word <= mem_rdata[ADDR_W-1:2];
            if (state == S_WBACK)  idx <= eor_q ? '0 : idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/rxr_engine_chk.sv
module rxr_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_re,
    input logic        mem_we,
    input logic        in_ready,
    input logic        host_wr,
    input logic        host_addr,
    input logic [1:0]  host_wdata,
    input logic [1:0]  irq_status,
    input logic [31:0] missed_count
);
    assert_single_access_R2: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    assert_irq_ok_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_status[0]) |-> $past(host_wr && !host_addr && host_wdata[0]));

    assert_irq_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_status[1]) |-> $past(host_wr && !host_addr && host_wdata[1]));

    assert_missed_step_R9: assert property (@(posedge clk) disable iff (rst)
        (missed_count != $past(missed_count)) |->
            (missed_count == $past(missed_count) + 32'd1 || missed_count == 32'd0));

    assert_missed_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr) |=> (missed_count == 32'd0));

    assert_ready_no_read_R11: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !mem_re);
endmodule

bind rxr_engine rxr_engine_chk u_chk (.*);

// File: tb/rxr_engine_bench.sv
module rxr_engine_bench;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-3:0] ring_base;
    logic          in_valid = 1'b0, in_last = 1'b0, in_crc_err = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready, mem_re, mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          host_wr = 1'b0, host_addr = 1'b0;
    logic [1:0]    host_wdata = '0;
    logic [1:0]    irq_status;
    logic [31:0]   missed_count;

    int checks = 0;
    int errors = 0;

    logic [31:0] mem [4096];
    logic [29:0] q_addr [$];
    logic [31:0] q_data [$];

    always #5 clk = ~clk;

    rxr_engine u_rxr_engine (
        .clk(clk), .rst(rst), .ring_base(ring_base),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_crc_err(in_crc_err), .in_ready(in_ready),
        .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .irq_status(irq_status), .missed_count(missed_count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory model plus per-clock comparison of every write against the reference queue
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
        if (!rst && mem_we) begin
            if (q_addr.size() == 0) begin
                chk("R2 unexpected write addr", 32'(mem_addr), 32'hFFFF_FFFF);
            end else begin
                chk("R2/R3 write addr", 32'(mem_addr), 32'(q_addr.pop_front()));
                chk("R2/R3 write data", mem_wdata, q_data.pop_front());
            end
            mem[mem_addr[11:0]] <= mem_wdata;
        end
    end

    initial begin : watchdog
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'((seed + i * 7) & 8'hFF);
    endfunction

    function automatic logic [29:0] dword(input int k);
        return 30'(32'h40 + 4 * k);
    endfunction

    function automatic logic [29:0] bword(input int k);
        return 30'(32'h400 + 32'h200 * k);
    endfunction

    task automatic arm(input int k, input bit eor, input int cap);
        mem[dword(k)]     = {1'b1, eor, 17'b0, 13'(cap)};
        mem[dword(k) + 2] = {bword(k), 2'b00};
    endtask

    // reference model: queue the writes a frame must produce
    task automatic expect_frame(input int k, input bit eor, input int len, input bit crc,
                                input int cap, input int seed);
        int stored = (len > cap) ? cap : len;
        bit lng = len > cap;
        bit sht = len < 64;
        for (int w = 0; w < (stored + 3) / 4; w++) begin
            logic [31:0] d = '0;
            for (int b = 0; b < 4; b++)
                if (w * 4 + b < stored) d[b*8 +: 8] = fbyte(seed, w * 4 + b);
            q_addr.push_back(bword(k) + 30'(w));
            q_data.push_back(d);
        end
        q_addr.push_back(dword(k));
        q_data.push_back({1'b0, eor, 7'b0, lng, (crc | sht | lng), sht, crc, 6'b0, 13'(stored)});
    endtask

    task automatic send_frame(input int len, input bit crc, input int seed);
        for (int i = 0; i < len; i++) begin
            bit done = 0;
            @(negedge clk);
            in_valid   = 1'b1;
            in_data    = fbyte(seed, i);
            in_last    = (i == len - 1);
            in_crc_err = crc && (i == len - 1);
            while (!done) begin
                #4;
                done = in_ready;
                @(negedge clk);
            end
            in_valid = 1'b0;
            in_last  = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic host_write(input bit a, input logic [1:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        ring_base = 30'h40;
        for (int k = 0; k < 4; k++) arm(k, k == 3, 1536);
        mem[bword(3) + 384] = 32'hA5A5_5A5A;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R8 reset irq", 32'(irq_status), 0);
        chk("R9 reset missed", missed_count, 0);
        chk("R11 reset ready", 32'(in_ready), 0);

        // good frame in descriptor 0
        expect_frame(0, 0, 100, 0, 1536, 3);
        send_frame(100, 0, 3);
        chk("R2 queue drained f1", q_addr.size(), 0);
        chk("R3 status desc0", mem[dword(0)], {19'b0, 13'd100});
        chk("R8 ok irq", 32'(irq_status), 32'd1);
        host_write(0, 2'b10);
        chk("R8 write zero keeps bit", 32'(irq_status), 32'd1);
        host_write(0, 2'b01);
        chk("R8 w1c clears", 32'(irq_status), 32'd0);

        // CRC error in descriptor 1
        expect_frame(1, 0, 64, 1, 1536, 9);
        send_frame(64, 1, 9);
        chk("R4 crc status", mem[dword(1)], 32'h0028_0040);
        chk("R8 err irq", 32'(irq_status), 32'd2);

        // runt with partial tail word in descriptor 2
        expect_frame(2, 0, 63, 0, 1536, 20);
        send_frame(63, 0, 20);
        chk("R5 runt status", mem[dword(2)], 32'h0030_003F);
        chk("R2 partial word", mem[bword(2) + 15], {8'h00, fbyte(20, 62), fbyte(20, 61), fbyte(20, 60)});

        // overlong frame in last descriptor
        expect_frame(3, 1, 1540, 0, 1536, 41);
        send_frame(1540, 0, 41);
        chk("R6 long status", mem[dword(3)], 32'h4060_0600);
        chk("R6 no write past capacity", mem[bword(3) + 384], 32'hA5A5_5A5A);
        chk("R2 queue drained f4", q_addr.size(), 0);
        host_write(0, 2'b11);
        chk("R8 clear both", 32'(irq_status), 32'd0);

        // descriptor 0 now host-owned: frame dropped
        send_frame(20, 0, 50);
        chk("R9 missed count", missed_count, 32'd1);
        chk("R9 no irq on drop", 32'(irq_status), 32'd0);
        chk("R9 desc untouched", mem[dword(0)], {19'b0, 13'd100});

        // rearm 0: after wrap the same index is used again
        arm(0, 0, 1536);
        expect_frame(0, 0, 70, 0, 1536, 77);
        send_frame(70, 0, 77);
        chk("R7 wrap to desc0", mem[dword(0)], {19'b0, 13'd70});
        chk("R1 index advanced to desc1", 32'(q_addr.size()), 0);
        host_write(1, 2'b00);
        chk("R10 counter cleared", missed_count, 32'd0);

        // descriptor 1 is host-owned again: second drop counted from zero
        send_frame(8, 0, 5);
        chk("R9 second drop", missed_count, 32'd1);
        chk("R11 idle ready low", 32'(in_ready), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule